// File: doc/BRIEF.md
# Complementary PWM Leg with Dead-Time Insertion

This block drives one half-bridge leg. A carrier counter runs over a programmable number of clock cycles. A compare value splits each carrier period into a high-side interval and a low-side interval. The block then turns that raw waveform into two gate enables, one for the high-side switch and one for the low-side switch. Every time the raw waveform changes level, both enables drop, and the switch for the new level is enabled only after a programmable number of idle cycles. The two switches therefore never conduct at the same time.

A one-cycle strobe marks the first cycle of each carrier period. Period and compare values take effect only at a period boundary, so a period is never cut short or stretched. Two inputs stop the leg:
- a run level, which must be high for the leg to operate;
- a kill level, which must be low for the leg to operate.

When the leg stops, both enables drop in the same cycle. When it restarts, a full dead interval passes before either switch is enabled.

An H-bridge uses two instances driven with the same period. At a 100 MHz clock, one dead-time count is 10 ns, so the default 6-bit field spans 0 to 630 ns. For a 16–20 kHz carrier at 100 MHz, the period input is set to between 5000 and 6250 cycles.

Top module: `pwm_deadband_leg`

## Requirements
- R1: `gate_hi_o` and `gate_lo_o` are never high in the same cycle.
- R2: When one enable falls because the raw level changed, the opposite enable rises only after `dead_i` consecutive cycles in which both are low. With `dead_i` = 0, the two enables swap on the same clock edge.
- R3: `dead_i` is an unsigned count of clock cycles over its full width (0 to 63 for the default 6 bits). A value of 50 gives a 50-cycle gap on each edge.
- R4: `period_i` (which must be at least 2) sets the carrier length in cycles. `cycle_start_o` is high for exactly one cycle per period, and consecutive strobes are `period_i` cycles apart.
- R5: In steady state with 0 < `dead_i` < `duty_i` and `duty_i` + `dead_i` < `period_i`:
  - the high side is enabled for `duty_i` − `dead_i` cycles per period;
  - the low side is enabled for `period_i` − `duty_i` − `dead_i` cycles per period.
- R6: With `duty_i` = 0, the high side is never enabled and the low side stays enabled for the whole period. With `duty_i` ≥ `period_i`, the high side stays enabled for the whole period and the low side is never enabled.
- R7: If a raw high interval lasts no longer than `dead_i`, no high-side pulse is produced. The low side resumes `dead_i` cycles after the raw level falls.
- R8: A change to `period_i` or `duty_i` in the middle of a period leaves that period's length and compare untouched. The new values apply from the next period.
- R9: When `kill_i` is high or `run_i` is low, both gate enables and `cycle_start_o` are low in that same cycle, and the counter is held at the start of a period.
- R10: On restart, `cycle_start_o` is high in the first active cycle. No gate enable rises until `dead_i` cycles have passed.
- R11: While `rst_ni` is low, both gate enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Leg operates while high |
| kill_i | input | 1 | Fault kill, forces both gates off while high |
| period_i | input | CNT_W | Carrier length in cycles |
| duty_i | input | CNT_W | Compare value, raw level high while counter below it |
| dead_i | input | DT_W | Dead interval in cycles |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |
| cycle_start_o | output | 1 | High in the first cycle of each carrier period |

## Verification
A wrong carrier count or a wrongly loaded shadow value shows up within one period, as a misplaced strobe or a pulse width that no longer matches duty minus dead time. A stuck or miscounted dead timer shows up at the next raw transition, as a gap that is shorter or longer than `dead_i`, or as a side that never turns on. An error in the stop path shows up in the very cycle kill is asserted, as an enable still high. An error in the restart path shows up within `dead_i` cycles of release, as an early enable.

// File: rtl/pwm_leg_pkg.sv
package pwm_leg_pkg;

  // Phase of the dead-time stage for one leg.
  typedef enum logic [1:0] {
    PH_SAFE  = 2'd0,  // stopped, no side selected
    PH_GAP   = 2'd1,  // both switches off, timer running
    PH_DRIVE = 2'd2   // selected side enabled
  } gap_phase_e;

endpackage

// File: rtl/pwm_leg_carrier.sv
module pwm_leg_carrier #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             raw_o,
  output logic             start_o
);

  localparam logic [CNT_W:0] INC_ONE = {{CNT_W{1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, duty_q;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap;
  logic             load_en;

  // Next-state: count up and wrap; shadows reload at the wrap or while stopped.
  always_comb begin
    cnt_inc = {1'b0, cnt_q} + INC_ONE;
    wrap    = (cnt_inc >= {1'b0, per_q});
    load_en = !active_i || wrap;
    cnt_d   = load_en ? '0 : cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
    end else if (load_en) begin
      per_q  <= period_i;
      duty_q <= duty_i;
    end
  end

  assign raw_o   = active_i && (cnt_q < duty_q);
  assign start_o = active_i && (cnt_q == '0);

  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && per_q != '0) |-> (cnt_q < per_q)); // R4

  AST_SHADOW_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i) && cnt_q != '0) |-> ($stable(per_q) && $stable(duty_q))); // R8

endmodule

// File: rtl/pwm_leg_deadgap.sv
module pwm_leg_deadgap
  import pwm_leg_pkg::*;
#(
  parameter int DT_W = 6
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            raw_i,
  input  logic [DT_W-1:0] dead_i,
  output logic [1:0]      gate_o    // [1] high side, [0] low side
);

  localparam logic [DT_W-1:0] TMR_ONE = {{(DT_W-1){1'b0}}, 1'b1};

  gap_phase_e      ph_q, ph_d;
  logic            side_q, side_d;
  logic [DT_W-1:0] tmr_q, tmr_d;
  logic [1:0]      gate_q, gate_d;

  // Next-state for phase, selected side and dead timer.
  always_comb begin
    ph_d   = ph_q;
    side_d = side_q;
    tmr_d  = tmr_q;
    if (!active_i) begin
      ph_d  = PH_SAFE;
      tmr_d = '0;
    end else if (ph_q == PH_SAFE || raw_i != side_q) begin
      side_d = raw_i;
      if (dead_i == '0) begin
        ph_d  = PH_DRIVE;
        tmr_d = '0;
      end else begin
        ph_d  = PH_GAP;
        tmr_d = dead_i;
      end
    end else if (ph_q == PH_GAP) begin
      if (tmr_q <= TMR_ONE) begin
        ph_d  = PH_DRIVE;
        tmr_d = '0;
      end else begin
        tmr_d = tmr_q - TMR_ONE;
      end
    end
  end

  // One enable per side, each from the next phase and side.
  for (genvar s = 0; s < 2; s++) begin : g_side
    always_comb gate_d[s] = (ph_d == PH_DRIVE) && (side_d == (s == 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_SAFE;
      side_q <= 1'b0;
      tmr_q  <= '0;
      gate_q <= '0;
    end else begin
      ph_q   <= ph_d;
      side_q <= side_d;
      tmr_q  <= tmr_d;
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q & {2{active_i}};

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[1] && gate_o[0])); // R1

  AST_HI_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_q[1]) && $past(gate_q[0])) |-> ($past(dead_i) == '0)); // R2

  AST_LO_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(gate_q[0]) && $past(gate_q[1])) |-> ($past(dead_i) == '0)); // R2

  AST_KILL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (ph_q == PH_SAFE && gate_q == '0)); // R9

  AST_KILL_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (gate_o == '0)); // R9

endmodule

// File: rtl/pwm_deadband_leg.sv
module pwm_deadband_leg #(
  parameter int CNT_W = 16,
  parameter int DT_W  = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             kill_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [DT_W-1:0]  dead_i,
  output logic             gate_hi_o,
  output logic             gate_lo_o,
  output logic             cycle_start_o
);

  logic       active;
  logic       raw;
  logic [1:0] gates;

  assign active = run_i && !kill_i;

  pwm_leg_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .period_i (period_i),
    .duty_i   (duty_i),
    .raw_o    (raw),
    .start_o  (cycle_start_o)
  );

  pwm_leg_deadgap #(.DT_W(DT_W)) u_deadgap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .raw_i    (raw),
    .dead_i   (dead_i),
    .gate_o   (gates)
  );

  assign gate_hi_o = gates[1];
  assign gate_lo_o = gates[0];

  AST_STROBE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_o |-> active); // R9

endmodule

// File: tb/pwm_deadband_leg_test.sv
module pwm_deadband_leg_test;

  localparam int CLK_NS = 10;
  localparam int CNT_W  = 16;
  localparam int DT_W   = 6;
  localparam int WATCHDOG_CYCLES = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run = 1'b0;
  logic             kill = 1'b0;
  logic [CNT_W-1:0] period = 16'd10;
  logic [CNT_W-1:0] duty = 16'd4;
  logic [DT_W-1:0]  dead = 6'd2;
  logic             gate_hi, gate_lo, cyc_start;

  int checks = 0;
  int errors = 0;
  int mon_overlap = 0;
  int mon_short_gap = 0;
  int off_run = 0;
  int last_on = 0;   // 0 none, 1 high side, 2 low side

  always #(CLK_NS/2) clk = ~clk;

  pwm_deadband_leg #(.CNT_W(CNT_W), .DT_W(DT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .kill_i(kill),
    .period_i(period), .duty_i(duty), .dead_i(dead),
    .gate_hi_o(gate_hi), .gate_lo_o(gate_lo), .cycle_start_o(cyc_start)
  );

  // Continuous monitor for R1 and R2, sampled after inputs settle.
  always @(negedge clk) begin
    #2;
    if (!rst_n || !run || kill) begin
      off_run = 0;
      last_on = 0;
    end else begin
      if (gate_hi && gate_lo) mon_overlap++;
      if (!gate_hi && !gate_lo) off_run++;
      if (gate_hi) begin
        if (last_on == 2 && off_run < int'(dead)) mon_short_gap++;
        last_on = 1;
        off_run = 0;
      end
      if (gate_lo) begin
        if (last_on == 1 && off_run < int'(dead)) mon_short_gap++;
        last_on = 2;
        off_run = 0;
      end
    end
  end

  task automatic expect_val(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sync_start();
    do @(negedge clk); while (!cyc_start);
  endtask

  task automatic configure(input int p, input int d, input int t);
    @(negedge clk);
    run = 1'b0; kill = 1'b0;
    period = CNT_W'(p); duty = CNT_W'(d); dead = DT_W'(t);
    @(negedge clk);
    run = 1'b1;
    sync_start();
    sync_start();
  endtask

  task automatic measure(input int n, output int hi, output int lo, output int stb, output int last_stb);
    hi = 0; lo = 0; stb = 0; last_stb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (gate_hi) hi++;
      if (gate_lo) lo++;
      if (cyc_start) stb++;
      last_stb = int'(cyc_start);
    end
  endtask

  task automatic run_window(input string req, input int p, input int d, input int t,
                            input int exp_hi, input int exp_lo);
    int hi, lo, stb, last_stb;
    configure(p, d, t);
    measure(p, hi, lo, stb, last_stb);
    expect_val(req, "high-side cycles", hi, exp_hi);
    expect_val(req, "low-side cycles", lo, exp_lo);
    expect_val("R4", "strobes per period", stb, 1);
    expect_val("R4", "strobe at period end", last_stb, 1);
  endtask

  task automatic test_reset();
    run = 1'b1;
    repeat (3) @(negedge clk);
    expect_val("R11", "gates during reset", int'(gate_hi) + int'(gate_lo), 0);
    run = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    expect_val("R11", "gates after reset, stopped", int'(gate_hi) + int'(gate_lo), 0);
  endtask

  task automatic test_stop(input bit use_kill);
    int seen = 0;
    configure(10, 4, 2);
    repeat (3) @(negedge clk);
    expect_val("R5", "high side on at count 3", int'(gate_hi), 1);
    if (use_kill) kill = 1'b1; else run = 1'b0;
    #1;
    expect_val("R9", "gates in stop cycle", int'(gate_hi) + int'(gate_lo), 0);
    repeat (3) begin
      @(negedge clk);
      seen += int'(gate_hi) + int'(gate_lo) + int'(cyc_start);
    end
    expect_val("R9", "outputs while stopped", seen, 0);
    @(negedge clk);
    kill = 1'b0; run = 1'b1;
    #1;
    expect_val("R10", "strobe in first active cycle", int'(cyc_start), 1);
    seen = 0;
    repeat (2) begin
      @(negedge clk);
      seen += int'(gate_hi) + int'(gate_lo);
    end
    expect_val("R10", "gates during restart gap", seen, 0);
    @(negedge clk);
    expect_val("R10", "high side after restart gap", int'(gate_hi), 1);
  endtask

  task automatic test_shadow();
    int n = 0;
    int hi, lo, stb, last_stb;
    configure(10, 4, 2);
    sync_start();
    do begin
      @(negedge clk);
      n++;
      if (n == 3) begin
        period = CNT_W'(16);
        duty   = CNT_W'(8);
      end
    end while (!cyc_start);
    expect_val("R8", "length of period with mid change", n, 10);
    measure(16, hi, lo, stb, last_stb);
    expect_val("R8", "new period length", stb + last_stb, 2);
    expect_val("R8", "high-side cycles with new duty", hi, 6);
    expect_val("R8", "low-side cycles with new duty", lo, 6);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    run_window("R5", 10, 4, 2, 2, 4);
    run_window("R5", 20, 15, 3, 12, 2);
    run_window("R3", 200, 100, 50, 50, 50);
    run_window("R2", 8, 3, 0, 3, 5);
    run_window("R6", 12, 0, 2, 0, 12);
    run_window("R6", 12, 12, 2, 12, 0);
    run_window("R6", 12, 20, 2, 12, 0);
    run_window("R7", 10, 2, 3, 0, 5);
    test_shadow();
    test_stop(1'b1);
    test_stop(1'b0);
    @(negedge clk);
    #3;
    expect_val("R1", "overlap cycles seen", mon_overlap, 0);
    expect_val("R2", "short dead gaps seen", mon_short_gap, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule